// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache with LRU Replacement

This block is a tiny word-addressed cache. It holds two sets of two ways, and each way stores one word. A request presents a word address. The low address bits select a set and the remaining bits form the tag. Both ways of the set are compared with the tag at the same time. A valid way whose tag matches is a hit, and its stored word is returned.

On a miss the block reads the word from a backing memory in the same cycle. The backing memory is combinational: the address goes out and the data comes back in the same cycle. The block returns that word and installs it in the set. The target way is the first empty way, way 0 before way 1. When both ways are full, the target is the way that one per-set LRU bit marks as least recently used.

Each access finishes in one clock. The response appears on the registered outputs after the next rising edge. Two counters record hits and misses since reset.

Top module: `twoway_lru_cache`

## Requirements
- R1: While and after reset, every way is invalid, `resp_valid` is 0 and both counters read 0. The first access to any address after reset is a miss.
- R2: The set is `req_addr[0]` and the tag is `req_addr[ADDR_W-1:1]`. An access whose tag matches a valid way of its set is a hit. One cycle later it gives `resp_valid`=1, `resp_hit`=1 and the word stored at fill time, even if the backing memory has changed since then.
- R3: A miss drives `mem_rd_en`=1 and `mem_rd_addr`=`req_addr` in the request cycle. One cycle later it gives `resp_hit`=0 and `resp_data` equal to the `mem_rd_data` seen in the request cycle. The word is then installed, so a repeat access to it hits. A hit drives `mem_rd_en`=0.
- R4: On a miss into a set with an invalid way, the word goes into the lowest-numbered invalid way. The other way's contents are kept.
- R5: On a miss into a set whose two ways are both valid, the way marked least recently used is overwritten. The other way's contents are kept.
- R6: After every hit or fill, the set's LRU bit marks the way that was not touched.
- R7: Each accepted access adds exactly one to `hit_count` on a hit or to `miss_count` on a miss. Both counters are visible together with the response.
- R8: From reset, the address sequence 0, 2, 0, 1, 4, 0, 2, 3, 5, 4 gives exactly 2 hits and 8 misses. The hits are the 3rd and 6th accesses.
- R9: A cycle with `req_valid`=0 gives `resp_valid`=0 on the next cycle and `mem_rd_en`=0. It changes no counter and no cache contents, whatever `req_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | ADDR_W | Word address of the access |
| mem_rd_en | output | 1 | Backing-memory read on a miss |
| mem_rd_addr | output | ADDR_W | Backing-memory word address |
| mem_rd_data | input | DATA_W | Backing-memory word, same cycle |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_hit | output | 1 | That access hit |
| resp_data | output | DATA_W | Word returned |
| hit_count | output | CNT_W | Hits since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
The hardest state to reach from the ports is a full set whose LRU bit points at a chosen way. Reaching it takes a specific history of fills and hits. A further difficulty is that a correct hit and a wrong refill can return the same word. To reach such states, the stimulus runs every three-access sequence over six addresses (three tags in each set) from reset, then a long pseudo-random run over ten addresses. During the long run the backing memory's contents are changed regularly. After each change, a hit must still return the word captured at fill time, while a miss returns the new word.

// File: rtl/twoway_cache_pkg.sv
package twoway_cache_pkg;

    typedef logic [0:0] way_t;

    // Fill target: lowest empty way, else the least recently used one.
    function automatic way_t pick_victim(input logic [1:0] vld, input logic lru);
        if (!vld[0])      return 1'b0;
        else if (!vld[1]) return 1'b1;
        else              return lru;
    endfunction

endpackage

// File: rtl/twoway_cache_lookup.sv
module twoway_cache_lookup
    import twoway_cache_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic [1:0]             rd_vld,
    input  logic [1:0][TAG_W-1:0]  rd_tag,
    input  logic [1:0][DATA_W-1:0] rd_dat,
    input  logic                   rd_lru,
    input  logic [TAG_W-1:0]       req_tag,
    output logic [1:0]             hit_vec,
    output logic                   hit,
    output way_t                   hit_way,
    output way_t                   vic_way,
    output logic [DATA_W-1:0]      hit_data
);

    // One comparator per way, evaluated in parallel.
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == req_tag);
    end

    assign hit      = |hit_vec;
    assign hit_way  = hit_vec[1];
    assign hit_data = hit_vec[1] ? rd_dat[1] : rd_dat[0];
    assign vic_way  = pick_victim(rd_vld, rd_lru);

endmodule

// File: rtl/twoway_cache_store.sv
module twoway_cache_store
    import twoway_cache_pkg::*;
#(
    parameter int SETS   = 2,
    parameter int IDX_W  = 1,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       acc_set,
    input  logic                   wr_en,
    input  way_t                   wr_way,
    input  logic [TAG_W-1:0]       wr_tag,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   touch_en,
    input  way_t                   touch_way,
    output logic [1:0]             rd_vld,
    output logic [1:0][TAG_W-1:0]  rd_tag,
    output logic [1:0][DATA_W-1:0] rd_dat,
    output logic                   rd_lru
);

    typedef struct packed {
        logic [SETS-1:0][1:0]             vld;
        logic [SETS-1:0][1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][1:0][DATA_W-1:0] dat;
        logic [SETS-1:0]                  lru;  // index of the least recently used way
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[acc_set][wr_way] = 1'b1;
            st_d.tag[acc_set][wr_way] = wr_tag;
            st_d.dat[acc_set][wr_way] = wr_data;
        end
        if (touch_en) begin
            st_d.lru[acc_set] = ~touch_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld = st_q.vld[acc_set];
    assign rd_tag = st_q.tag[acc_set];
    assign rd_dat = st_q.dat[acc_set];
    assign rd_lru = st_q.lru[acc_set];

    // R4: a fill into a set with way 0 empty lands in way 0
    p_fill_empty_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.vld[acc_set][0]) |-> (wr_way == 1'b0));

    // R5: a fill into a full set overwrites the recorded LRU way
    p_victim_is_lru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&st_q.vld[acc_set])) |-> (wr_way == st_q.lru[acc_set]));

    // R6: after a touch the set's LRU bit names the untouched way
    p_lru_other_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (st_q.lru[$past(acc_set)] != $past(touch_way)));

endmodule

// File: rtl/twoway_lru_cache.sv
module twoway_lru_cache
    import twoway_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SETS   = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              resp_valid;
        logic              resp_hit;
        logic [DATA_W-1:0] resp_data;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
    } top_t;

    top_t top_d, top_q;

    logic [IDX_W-1:0]       req_set;
    logic [TAG_W-1:0]       req_tag;
    logic [1:0]             rd_vld;
    logic [1:0][TAG_W-1:0]  rd_tag;
    logic [1:0][DATA_W-1:0] rd_dat;
    logic                   rd_lru;
    logic [1:0]             hit_vec;
    logic                   hit;
    way_t                   hit_way;
    way_t                   vic_way;
    logic [DATA_W-1:0]      hit_data;
    logic                   fill_en;
    way_t                   touch_way;

    assign req_set   = req_addr[IDX_W-1:0];
    assign req_tag   = req_addr[ADDR_W-1:IDX_W];
    assign fill_en   = req_valid && !hit;
    assign touch_way = hit ? hit_way : vic_way;

    twoway_cache_store #(
        .SETS   (SETS),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_set   (req_set),
        .wr_en     (fill_en),
        .wr_way    (vic_way),
        .wr_tag    (req_tag),
        .wr_data   (mem_rd_data),
        .touch_en  (req_valid),
        .touch_way (touch_way),
        .rd_vld    (rd_vld),
        .rd_tag    (rd_tag),
        .rd_dat    (rd_dat),
        .rd_lru    (rd_lru)
    );

    twoway_cache_lookup #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) i_lookup (
        .rd_vld   (rd_vld),
        .rd_tag   (rd_tag),
        .rd_dat   (rd_dat),
        .rd_lru   (rd_lru),
        .req_tag  (req_tag),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_way  (hit_way),
        .vic_way  (vic_way),
        .hit_data (hit_data)
    );

    always_comb begin
        top_d            = top_q;
        top_d.resp_valid = req_valid;
        if (req_valid) begin
            top_d.resp_hit  = hit;
            top_d.resp_data = hit ? hit_data : mem_rd_data;
            if (hit) top_d.hits   = top_q.hits + CNT_W'(1);
            else     top_d.misses = top_q.misses + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign mem_rd_en   = fill_en;
    assign mem_rd_addr = req_addr;
    assign resp_valid  = top_q.resp_valid;
    assign resp_hit    = top_q.resp_hit;
    assign resp_data   = top_q.resp_data;
    assign hit_count   = top_q.hits;
    assign miss_count  = top_q.misses;

    logic [CNT_W-1:0] total_cnt;
    assign total_cnt = top_q.hits + top_q.misses;

    // R2: a tag never sits in both ways of one set
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(hit_vec) <= 1));

    // R3: every miss response was preceded by a memory read
    p_miss_reads_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(mem_rd_en));

    // R7: each response advances the two counters by exactly one in total
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (total_cnt == $past(total_cnt) + CNT_W'(1)));

    // R9: an idle cycle produces no response and leaves the counters alone
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && $stable(total_cnt)));

    // R9: no memory traffic without a request
    p_idle_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !mem_rd_en);

endmodule

// File: tb/test_twoway_lru_cache.sv
module test_twoway_lru_cache;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;
    logic              resp_valid;
    logic              resp_hit;
    logic [DATA_W-1:0] resp_data;
    logic [CNT_W-1:0]  hit_count;
    logic [CNT_W-1:0]  miss_count;
    logic [7:0]        salt = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference state: [set][way]
    bit              m_vld [2][2];
    logic [6:0]      m_tag [2][2];
    logic [15:0]     m_dat [2][2];
    bit              m_lru [2];
    int              m_hits;
    int              m_miss;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Single-cycle backing memory; contents move with salt.
    always_comb mem_rd_data = {mem_rd_addr, mem_rd_addr ^ salt};

    twoway_lru_cache #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SETS   (2),
        .CNT_W  (CNT_W)
    ) i_twoway_lru_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .resp_valid  (resp_valid),
        .resp_hit    (resp_hit),
        .resp_data   (resp_data),
        .hit_count   (hit_count),
        .miss_count  (miss_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 2; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_vld[s][w] = 0;
                m_tag[s][w] = '0;
                m_dat[s][w] = '0;
            end
        end
        m_hits = 0;
        m_miss = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 0);
        chk(hit_count == '0 && miss_count == '0, "R1", "counters in reset",
            32'(hit_count + miss_count), 0);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at the next falling edge with
    // the response checked. Leaves req_valid asserted.
    task automatic access(input logic [7:0] a, input string req, output bit was_hit);
        int   s;
        logic [6:0] t;
        int   hw;
        int   vw;
        logic [15:0] exp_d;
        s  = int'(a[0]);
        t  = a[7:1];
        hw = -1;
        for (int w = 0; w < 2; w++)
            if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(mem_rd_en == (hw < 0), "R3", "mem_rd_en", 32'(mem_rd_en), 32'(hw < 0));
        if (hw < 0)
            chk(mem_rd_addr == a, "R3", "mem_rd_addr", 32'(mem_rd_addr), 32'(a));
        if (hw >= 0) begin
            exp_d = m_dat[s][hw];
            m_lru[s] = (hw == 0);
            m_hits++;
        end else begin
            exp_d = {a, a ^ salt};
            if (!m_vld[s][0])      vw = 0;
            else if (!m_vld[s][1]) vw = 1;
            else                   vw = m_lru[s] ? 1 : 0;
            m_vld[s][vw] = 1;
            m_tag[s][vw] = t;
            m_dat[s][vw] = exp_d;
            m_lru[s] = (vw == 0);
            m_miss++;
        end
        @(negedge clk);
        was_hit = resp_hit;
        chk(resp_valid == 1'b1, req, "resp_valid", 32'(resp_valid), 1);
        chk(resp_hit == (hw >= 0), req, "resp_hit", 32'(resp_hit), 32'(hw >= 0));
        chk(resp_data == exp_d, req, "resp_data", 32'(resp_data), 32'(exp_d));
        chk(int'(hit_count) == m_hits, "R7", "hit_count", 32'(hit_count), 32'(m_hits));
        chk(int'(miss_count) == m_miss, "R7", "miss_count", 32'(miss_count), 32'(m_miss));
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin : main
        bit h;
        logic [15:0] lfsr;
        logic [7:0]  seq [10];
        logic [31:0] snap_h;
        logic [31:0] snap_m;

        do_reset();

        // R1: after reset the first access misses
        access(8'd0, "R1", h);
        chk(h == 1'b0, "R1", "first access after reset", 32'(h), 0);
        idle(1);

        // R8: reference sequence from reset
        do_reset();
        seq = '{8'd0, 8'd2, 8'd0, 8'd1, 8'd4, 8'd0, 8'd2, 8'd3, 8'd5, 8'd4};
        for (int i = 0; i < 10; i++) begin
            access(seq[i], "R8", h);
            chk(h == ((i == 2) || (i == 5)), "R8", $sformatf("hit at position %0d", i + 1),
                32'(h), 32'((i == 2) || (i == 5)));
        end
        idle(1);
        chk(hit_count == 16'd2 && miss_count == 16'd8, "R8", "final hits/misses",
            {hit_count, miss_count}, {16'd2, 16'd8});

        // R4 / R5 / R6 directed on set 0: fill 0 (way0), 2 (way1), hit 0, miss 4 -> evicts 2
        do_reset();
        access(8'd0, "R4", h);
        access(8'd2, "R4", h);
        access(8'd0, "R6", h);
        chk(h == 1'b1, "R6", "hit on way0", 32'(h), 1);
        access(8'd4, "R5", h);
        access(8'd0, "R5", h);
        chk(h == 1'b1, "R5", "MRU way kept", 32'(h), 1);
        access(8'd2, "R5", h);
        chk(h == 1'b0, "R5", "LRU way was evicted", 32'(h), 0);
        // Set 1 untouched by set-0 traffic (R2 index decode)
        access(8'd1, "R2", h);
        chk(h == 1'b0, "R2", "set 1 still empty", 32'(h), 0);
        access(8'd1, "R2", h);
        chk(h == 1'b1, "R2", "set 1 refetch hits", 32'(h), 1);

        // R9: idle cycles with a moving address change nothing
        req_valid = 1'b0;
        snap_h = 32'(hit_count);
        snap_m = 32'(miss_count);
        for (int i = 0; i < 8; i++) begin
            req_addr = 8'(i * 37 + 3);
            #1;
            chk(mem_rd_en == 1'b0, "R9", "mem_rd_en idle", 32'(mem_rd_en), 0);
            @(negedge clk);
            chk(resp_valid == 1'b0, "R9", "resp_valid idle", 32'(resp_valid), 0);
            chk(32'(hit_count) == snap_h && 32'(miss_count) == snap_m, "R9",
                "counters idle", 32'(hit_count + miss_count), snap_h + snap_m);
        end
        access(8'd1, "R9", h);
        chk(h == 1'b1, "R9", "contents kept over idle", 32'(h), 1);
        idle(1);

        // Near-exhaustive: every 3-access sequence over addresses 0..5
        for (int a0 = 0; a0 < 6; a0++)
            for (int a1 = 0; a1 < 6; a1++)
                for (int a2 = 0; a2 < 6; a2++) begin
                    do_reset();
                    access(8'(a0), "R4", h);
                    access(8'(a1), "R6", h);
                    access(8'(a2), "R5", h);
                    idle(1);
                end

        // Long pseudo-random run; memory contents drift so stale-vs-refetch is visible (R2, R3)
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 249) salt = salt + 8'h5B;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(8'(int'(lfsr[7:0]) % 10), (i % 2 == 0) ? "R2" : "R3", h);
            if (lfsr[11:9] == 3'b000) idle(1);
        end
        idle(1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule